// File: doc/BRIEF.md
# Interrupt Enable and Breakpoint Unit

This block sits on the register bus of a small 16-bit microcontroller. It catches single-cycle or level event signals from two timers, a set of GPIO pins and a UART with separate transmit and receive events. Each source has a pending flag that is set on a rising edge of its event. A per-source enable bit gates these flags onto interrupt request lines. Turning an enable bit off also discards whatever that source had pending. Software can also clear individual flags by writing ones to a status word.

The same unit holds a breakpoint address. While that address is nonzero and the program counter equals it, a sticky debug interrupt (vector 127 in the system map) is raised. It stays up after the program counter moves on, and software removes it only by writing zero to the breakpoint register. The bus is a plain single-cycle write strobe with a combinational read mux over four word offsets.

Top module: `irq_bp_unit`

## Requirements
- R1: After synchronous reset, the enable word, all pending flags and the breakpoint address are 0, and every interrupt output is low.
- R2: The enable word is at offset 0. Bit 0 enables timer 0, bit 1 enables timer 1, bit 2 enables GPIO and bit 3 enables both UART events. A 1 enables the source. Bits 15:4 are ignored on write and read back as 0.
- R3: A pending flag is set in the cycle after its event input is first sampled high following a low sample. An event held high does not set the flag again after it has been cleared.
- R4: Each interrupt output is high exactly while its source has a pending flag and its enable bit is 1. `irq_uart` is high when either UART flag is pending and bit 3 is set. `irq_gpio` is high when any GPIO flag is pending and bit 2 is set.
- R5: Pending flags are latched even while their source is disabled. Setting the enable bit afterwards raises the interrupt with no new event.
- R6: Writing the enable word with a source's bit at 0 clears all of that source's pending flags: both UART flags for bit 3, and every pin flag for bit 2. If an event rises in the same cycle, the clear wins.
- R7: The status word is at offset 1, with bit 0 for timer 0, bit 1 for timer 1, bit 2 for UART transmit and bit 3 for UART receive. Bits 15:4 read as 0. Writing a 1 to a bit clears that flag, and writing 0 leaves it unchanged. A rising event in the same cycle wins over this clear.
- R8: The GPIO pending word is at offset 2, with bit i for pin i. Bits at and above the pin count read as 0. Writing 1 clears the flag of that pin, and a same-cycle rising edge wins.
- R9: The breakpoint address is a 16-bit read/write register at offset 3.
- R10: When the breakpoint address is nonzero and equals `pc_i`, the breakpoint flag is set one cycle later and drives `irq_bp`. The flag stays set after `pc_i` changes, and writing a nonzero address does not clear it. An address of 0 never matches.
- R11: Writing 0 to the breakpoint register clears the breakpoint flag, and this clear wins over a match in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| ev_tm0 | input | 1 | Timer 0 event |
| ev_tm1 | input | 1 | Timer 1 event |
| ev_gpio | input | GPIO_N | GPIO pin events |
| ev_uart_tx | input | 1 | UART transmit event |
| ev_uart_rx | input | 1 | UART receive event |
| pc_i | input | 16 | Core program counter |
| irq_tm0 | output | 1 | Timer 0 interrupt request |
| irq_tm1 | output | 1 | Timer 1 interrupt request |
| irq_gpio | output | 1 | GPIO interrupt request |
| irq_uart | output | 1 | UART interrupt request |
| irq_bp | output | 1 | Breakpoint debug interrupt |

## Verification
The bench builds the unit with eight GPIO pins. This leaves the upper half of the GPIO pending word unused, so its read-as-zero bits are checked, while a random pin mask still often holds several pins pending at once. The program counter and breakpoint values are drawn from a range of only eight values that includes zero. Matches, the zero-address case and zero writes that land on a live match therefore occur often in random traffic. Directed steps then force the same-cycle races between event edges and clears.

// File: rtl/irq_bp_pkg.sv
package irq_bp_pkg;

    localparam int DATA_W   = 16;
    localparam int SRC_W    = 4;   // tm0, tm1, uart_tx, uart_rx flags
    localparam int EN_W     = 4;   // enable bits that exist
    localparam int OFF_W    = 2;
    localparam int GPIO_MAX = DATA_W;

    typedef enum logic [OFF_W-1:0] {
        OFF_ENABLE = 2'd0,
        OFF_STATUS = 2'd1,
        OFF_GPIO   = 2'd2,
        OFF_BREAK  = 2'd3
    } reg_off_e;

    // Enable word layout, MSB first: bit3 uart, bit2 gpio, bit1 tm1, bit0 tm0
    typedef struct packed {
        logic uart;
        logic gpio;
        logic tm1;
        logic tm0;
    } irq_en_t;

    typedef struct packed {
        logic                 wr_en;
        logic                 wr_stat;
        logic                 wr_gpio;
        logic                 wr_bp;
    } wr_strobe_t;

    // Flags in the status word flushed when an enable word is written.
    // Status layout: bit0 tm0, bit1 tm1, bit2 uart_tx, bit3 uart_rx.
    function automatic logic [SRC_W-1:0] src_flush(input irq_en_t nv);
        return {~nv.uart, ~nv.uart, ~nv.tm1, ~nv.tm0};
    endfunction

    function automatic logic [DATA_W-1:0] zext_src(input logic [SRC_W-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[SRC_W-1:0] = v;
        return r;
    endfunction

endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_bp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [OFF_W-1:0] bus_addr,
    input  logic [EN_W-1:0] wdata_lo,
    output irq_en_t         en_o,
    output wr_strobe_t      wr_o
);

    irq_en_t    en_q;
    wr_strobe_t wr;
    logic       wr_any;

    assign wr_any = bus_sel & bus_we;

    always_comb begin
        wr = '0;
        if (wr_any) begin
            case (reg_off_e'(bus_addr))
                OFF_ENABLE: wr.wr_en   = 1'b1;
                OFF_STATUS: wr.wr_stat = 1'b1;
                OFF_GPIO:   wr.wr_gpio = 1'b1;
                OFF_BREAK:  wr.wr_bp   = 1'b1;
                default:    wr         = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr.wr_en) begin
            en_q <= irq_en_t'(wdata_lo);
        end
    end

    assign en_o = en_q;
    assign wr_o = wr;

    a_r2_enable_written: assert property (@(posedge clk) disable iff (rst)
        wr.wr_en |=> (en_o == $past(irq_en_t'(wdata_lo))));

    a_r2_enable_held: assert property (@(posedge clk) disable iff (rst)
        !wr.wr_en |=> $stable(en_o));

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr));

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev_i,
    input  logic [W-1:0] flush_i,
    input  logic [W-1:0] w1c_i,
    output logic [W-1:0] pend_o
);

    logic [W-1:0] prev_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] rise;

    for (genvar i = 0; i < W; i++) begin : g_flag
        assign rise[i] = ev_i[i] & ~prev_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i] <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= ev_i[i];
                if (flush_i[i])
                    pend_q[i] <= 1'b0;
                else if (rise[i])
                    pend_q[i] <= 1'b1;
                else if (w1c_i[i])
                    pend_q[i] <= 1'b0;
            end
        end

        a_r6_flush_wins: assert property (@(posedge clk) disable iff (rst)
            flush_i[i] |=> !pend_o[i]);

        a_r3_edge_sets: assert property (@(posedge clk) disable iff (rst)
            (ev_i[i] && !prev_q[i] && !flush_i[i]) |=> pend_o[i]);

        a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
            (w1c_i[i] && !rise[i] && !flush_i[i]) |=> !pend_o[i]);

        a_r3_level_holds: assert property (@(posedge clk) disable iff (rst)
            (!rise[i] && !w1c_i[i] && !flush_i[i]) |=> $stable(pend_o[i]));
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/bp_unit.sv
module bp_unit
    import irq_bp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] pc_i,
    output logic [DATA_W-1:0] addr_o,
    output logic              pend_o
);

    logic [DATA_W-1:0] addr_q;
    logic              pend_q;
    logic              armed;
    logic              hit;
    logic              zero_wr;

    assign armed   = (addr_q != '0);
    assign hit     = armed && (pc_i == addr_q);
    assign zero_wr = wr_i && (wdata_i == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (wr_i)
                addr_q <= wdata_i;
            if (zero_wr)
                pend_q <= 1'b0;
            else if (hit)
                pend_q <= 1'b1;
        end
    end

    assign addr_o = addr_q;
    assign pend_o = pend_q;

    a_r9_addr_written: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (addr_o == $past(wdata_i)));

    a_r10_match_sets: assert property (@(posedge clk) disable iff (rst)
        (addr_o != '0 && pc_i == addr_o && !zero_wr) |=> pend_o);

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !zero_wr) |=> pend_o);

    a_r10_zero_never_hits: assert property (@(posedge clk) disable iff (rst)
        (addr_o == '0 && !pend_o) |=> !pend_o);

    a_r11_zero_clears: assert property (@(posedge clk) disable iff (rst)
        zero_wr |=> !pend_o);

endmodule

// File: rtl/irq_bp_unit.sv
module irq_bp_unit
    import irq_bp_pkg::*;
#(
    parameter int GPIO_N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [OFF_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_tm0,
    input  logic              ev_tm1,
    input  logic [GPIO_N-1:0] ev_gpio,
    input  logic              ev_uart_tx,
    input  logic              ev_uart_rx,
    input  logic [DATA_W-1:0] pc_i,
    output logic              irq_tm0,
    output logic              irq_tm1,
    output logic              irq_gpio,
    output logic              irq_uart,
    output logic              irq_bp
);

    irq_en_t           en;
    wr_strobe_t        wr;
    logic [SRC_W-1:0]  src_ev, src_flush_v, src_w1c, src_pend;
    logic [GPIO_N-1:0] gp_flush, gp_w1c, gp_pend;
    logic [DATA_W-1:0] bp_addr;
    logic              bp_pend;
    irq_en_t           en_new;

    assign en_new = irq_en_t'(bus_wdata[EN_W-1:0]);

    irq_ctrl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wdata_lo (bus_wdata[EN_W-1:0]),
        .en_o     (en),
        .wr_o     (wr)
    );

    // Status bit order: tm0, tm1, uart_tx, uart_rx
    assign src_ev      = {ev_uart_rx, ev_uart_tx, ev_tm1, ev_tm0};
    assign src_flush_v = {SRC_W{wr.wr_en}} & src_flush(en_new);
    assign src_w1c     = {SRC_W{wr.wr_stat}} & bus_wdata[SRC_W-1:0];

    irq_pend_bank #(.W(SRC_W)) u_src_bank (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (src_ev),
        .flush_i (src_flush_v),
        .w1c_i   (src_w1c),
        .pend_o  (src_pend)
    );

    assign gp_flush = {GPIO_N{wr.wr_en & ~en_new.gpio}};
    assign gp_w1c   = {GPIO_N{wr.wr_gpio}} & bus_wdata[GPIO_N-1:0];

    irq_pend_bank #(.W(GPIO_N)) u_gpio_bank (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev_gpio),
        .flush_i (gp_flush),
        .w1c_i   (gp_w1c),
        .pend_o  (gp_pend)
    );

    bp_unit u_bp (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr.wr_bp),
        .wdata_i (bus_wdata),
        .pc_i    (pc_i),
        .addr_o  (bp_addr),
        .pend_o  (bp_pend)
    );

    assign irq_tm0  = src_pend[0] & en.tm0;
    assign irq_tm1  = src_pend[1] & en.tm1;
    assign irq_uart = (src_pend[2] | src_pend[3]) & en.uart;
    assign irq_gpio = (|gp_pend) & en.gpio;
    assign irq_bp   = bp_pend;

    always_comb begin
        bus_rdata = '0;
        case (reg_off_e'(bus_addr))
            OFF_ENABLE: bus_rdata = zext_src(en);
            OFF_STATUS: bus_rdata = zext_src(src_pend);
            OFF_GPIO:   bus_rdata[GPIO_N-1:0] = gp_pend;
            OFF_BREAK:  bus_rdata = bp_addr;
            default:    bus_rdata = '0;
        endcase
    end

    initial a_r8_gpio_width: assert (GPIO_N >= 1 && GPIO_N <= GPIO_MAX);

    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr.wr_en && !en_new.tm0 && !en_new.tm1 && !en_new.gpio && !en_new.uart)
        |=> !(irq_tm0 || irq_tm1 || irq_gpio || irq_uart));

endmodule

// File: tb/irq_bp_unit_tb_top.sv
module irq_bp_unit_tb_top;

    localparam int GN = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_we;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        ev_tm0, ev_tm1, ev_uart_tx, ev_uart_rx;
    logic [GN-1:0] ev_gpio;
    logic [15:0] pc_i;
    logic        irq_tm0, irq_tm1, irq_gpio, irq_uart, irq_bp;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    logic [3:0]    m_en, m_pend, m_prev4;
    logic [GN-1:0] m_gp, m_prevg;
    logic [15:0]   m_bp;
    logic          m_bpp;

    always #2 clk = ~clk;

    irq_bp_unit #(.GPIO_N(GN)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_tm0(ev_tm0), .ev_tm1(ev_tm1), .ev_gpio(ev_gpio),
        .ev_uart_tx(ev_uart_tx), .ev_uart_rx(ev_uart_rx), .pc_i(pc_i),
        .irq_tm0(irq_tm0), .irq_tm1(irq_tm1), .irq_gpio(irq_gpio),
        .irq_uart(irq_uart), .irq_bp(irq_bp)
    );

    function automatic logic [4:0] exp_irq();
        return {m_bpp, (m_pend[2] | m_pend[3]) & m_en[3], (|m_gp) & m_en[2],
                m_pend[1] & m_en[1], m_pend[0] & m_en[0]};
    endfunction

    function automatic logic [15:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {12'b0, m_en};
            2'd1:    return {12'b0, m_pend};
            2'd2:    return {{(16-GN){1'b0}}, m_gp};
            default: return m_bp;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ev4 = {uart_rx, uart_tx, tm1, tm0}
    task automatic step(input logic we, input logic [1:0] a, input logic [15:0] d,
                        input logic [3:0] ev4, input logic [GN-1:0] gev,
                        input logic [15:0] pc, input string tag);
        logic [3:0]    r4, fl4, c4;
        logic [GN-1:0] rg, flg, cg;
        logic          zw, hit;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        {ev_uart_rx, ev_uart_tx, ev_tm1, ev_tm0} = ev4;
        ev_gpio = gev; pc_i = pc;
        @(posedge clk);
        #1;
        r4  = ev4 & ~m_prev4;
        rg  = gev & ~m_prevg;
        fl4 = (we && a == 2'd0) ? ~{d[3], d[3], d[1], d[0]} : 4'b0;
        flg = (we && a == 2'd0 && !d[2]) ? '1 : '0;
        c4  = (we && a == 2'd1) ? d[3:0] : 4'b0;
        cg  = (we && a == 2'd2) ? d[GN-1:0] : '0;
        m_pend  = ((m_pend & ~c4) | r4) & ~fl4;
        m_gp    = ((m_gp & ~cg) | rg) & ~flg;
        m_prev4 = ev4;
        m_prevg = gev;
        zw  = we && a == 2'd3 && d == 16'd0;
        hit = (m_bp != 16'd0) && (pc == m_bp);
        if (zw) m_bpp = 1'b0; else if (hit) m_bpp = 1'b1;
        if (we && a == 2'd3) m_bp = d;
        if (we && a == 2'd0) m_en = d[3:0];
        chk({tag, " irq"}, {11'b0, irq_bp, irq_uart, irq_gpio, irq_tm1, irq_tm0},
            {11'b0, exp_irq()});
        chk({tag, " rdata"}, bus_rdata, exp_rd(a));
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        step(1'b0, a, 16'h0, m_prev4, m_prevg, 16'h0, tag);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        ev_tm0 = 0; ev_tm1 = 0; ev_uart_tx = 0; ev_uart_rx = 0; ev_gpio = '0; pc_i = 0;
        m_en = 0; m_pend = 0; m_prev4 = 0; m_gp = 0; m_prevg = 0; m_bp = 0; m_bpp = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset values on every offset
        for (int a = 0; a < 4; a++) rd(2'(a), "R1 reset");

        // R2 reserved bits ignored, read 0
        step(1, 2'd0, 16'hFFF0, 4'h0, '0, 16'h0, "R2 reserved only");
        step(1, 2'd0, 16'hFFFF, 4'h0, '0, 16'h0, "R2 all ones");
        rd(2'd0, "R2 readback");

        // R3/R4 edge sets flag, irq follows enable
        step(0, 2'd1, 0, 4'b0001, '0, 0, "R3 tm0 edge");
        step(0, 2'd1, 0, 4'b0001, '0, 0, "R3 tm0 held");
        step(1, 2'd1, 16'h0001, 4'b0001, '0, 0, "R7 w1c tm0 level held");
        rd(2'd1, "R3 no re-set while held");
        step(0, 2'd1, 0, 4'b0100, '0, 0, "R4 uart tx");
        step(0, 2'd1, 0, 4'b1000, '0, 0, "R4 uart rx");

        // R6 flush of both uart flags, R5 latch while disabled
        step(1, 2'd0, 16'h0007, 4'b0000, '0, 0, "R6 uart flush");
        step(0, 2'd1, 0, 4'b0010, '0, 0, "R5 tm1 edge");
        step(1, 2'd0, 16'h0005, 4'b0000, '0, 0, "R6 tm1 flush");
        step(0, 2'd1, 0, 4'b0010, 8'h81, 0, "R5 disabled latch");
        step(0, 2'd1, 0, 4'b0000, 8'h00, 0, "R5 events low");
        step(1, 2'd0, 16'h000F, 4'b0000, 8'h00, 0, "R5 enable later");
        rd(2'd2, "R8 gpio pend");

        // R6 flush wins over simultaneous edge
        step(1, 2'd0, 16'h000B, 4'b0000, 8'h10, 0, "R6 gpio flush vs edge");
        rd(2'd2, "R6 gpio cleared");

        // R7/R8 same-cycle edge beats w1c
        step(0, 2'd1, 0, 4'b0000, 8'h00, 0, "R7 lows");
        step(1, 2'd1, 16'h000F, 4'b0001, 8'h00, 0, "R7 edge beats w1c");
        step(0, 2'd2, 0, 4'b0001, 8'h02, 0, "R8 pin1 edge");
        step(1, 2'd2, 16'h00FF, 4'b0001, 8'h06, 0, "R8 pin2 edge beats w1c");

        // R9/R10/R11 breakpoint
        step(0, 2'd3, 0, 4'b0000, '0, 16'h0000, "R10 zero addr no match");
        step(1, 2'd3, 16'h1234, 4'b0000, '0, 16'h0000, "R9 write addr");
        step(0, 2'd3, 0, 4'b0000, '0, 16'h1234, "R10 match");
        step(0, 2'd3, 0, 4'b0000, '0, 16'h0042, "R10 sticky");
        step(1, 2'd3, 16'h0042, 4'b0000, '0, 16'h0000, "R10 nonzero write keeps");
        step(1, 2'd3, 16'h0000, 4'b0000, '0, 16'h0042, "R11 zero beats match");
        step(0, 2'd3, 0, 4'b0000, '0, 16'h0000, "R11 cleared");

        // random traffic
        for (int k = 0; k < 3000; k++) begin
            logic        we;
            logic [1:0]  a;
            logic [15:0] d;
            we = ($urandom_range(0, 3) == 0);
            a  = 2'($urandom_range(0, 3));
            d  = (a == 2'd3) ? 16'($urandom_range(0, 7)) : 16'($urandom);
            step(we, a, d, 4'($urandom) & 4'($urandom), GN'($urandom) & GN'($urandom),
                 16'($urandom_range(0, 7)), "R4 R7 R10 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule